// File: doc/BRIEF.md
# DSP Address Generation and Post-Modify Unit

This block generates data-memory addresses for the load and store operations of a small 16-bit DSP. It holds a bank of address registers and an equal number of index registers. Each address register has one fixed partner in the index bank. For every access, the selected address register drives the memory address. The unit then updates that register with one post-access rule: keep, step down, step up, or add the partner index register.

One request can carry two accesses. The first is a main load/store. The second is an extension-slot access taken from the low byte of the same opcode. The main access goes first. When both are present, the extension access runs in the next cycle, and the unit lowers `req_ready` during that cycle. Loaded words leave through a register-write port. Store data comes from the unit's own registers or from a register-read port into the wider register file.

Top module: `dsp_agu`

## Requirements
- R1: A synchronous active-high `rst` clears every address register and every index register to zero.
- R2: During an access, `mem_addr` carries the selected address register's value before that access's update. `mem_en` is high only in the cycles in which an access executes.
- R3: A main access updates its address register according to `main_mode`: 0 keeps it, 1 subtracts one, 2 adds one, 3 adds the partner index register.
- R4: Register numbers 0 to 3 name the address registers and 4 to 7 name the index registers. Address register N is always paired with index register N, which is register 4+N.
- R5: All address arithmetic wraps modulo 2^16. The index register is added as a two's-complement value.
- R6: An extension load writes the loaded word to register 24+F, where F is `ext_field`. Its update is +1 when `ext_addidx`=0 and +index when `ext_addidx`=1.
- R7: An extension store takes its data from register 28+F, uses the same two update rules, and writes to the address in the selected address register.
- R8: A request with both slots enabled runs the main access in the accept cycle and the extension access in the next cycle. `req_ready` is low in that second cycle. The extension access sees the address register as the main update left it. A request with only the extension enabled runs in its accept cycle.
- R9: When a load targets the same address register that the access updates, the loaded word wins over the post-update.
- R10: A load drives `rf_we` with `rf_waddr` equal to the destination and `rf_wdata` equal to `mem_rdata` in the access cycle. A store never asserts `rf_we` and asserts `mem_we`.
- R11: Store data for registers 0 to 7 comes from the unit's own registers before the update. For any other register it comes from `rf_rdata`, while `rf_raddr` names that register.
- R12: `pc_inc` pulses for exactly one cycle for each main access, in that access's cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Decoded request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| main_en | input | 1 | Main load/store slot used |
| main_store | input | 1 | Main slot is a store (0 = load) |
| main_mode | input | 2 | Main update: 0 keep, 1 dec, 2 inc, 3 add index |
| main_ar | input | 2 | Main address register select |
| main_rsel | input | 5 | Main destination or source register number |
| ext_en | input | 1 | Extension slot used |
| ext_store | input | 1 | Extension slot is a store |
| ext_addidx | input | 1 | Extension update: 0 inc, 1 add index |
| ext_ar | input | 2 | Extension address register select |
| ext_field | input | 2 | Extension register field F |
| mem_en | output | 1 | Data-memory access this cycle |
| mem_we | output | 1 | Data-memory write |
| mem_addr | output | 16 | Data-memory address |
| mem_wdata | output | 16 | Data-memory write data |
| mem_rdata | input | 16 | Data-memory read data, same cycle |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 5 | Register-file write number |
| rf_wdata | output | 16 | Register-file write data |
| rf_raddr | output | 5 | Register-file read number for store data |
| rf_rdata | input | 16 | Register-file read data, same cycle |
| pc_inc | output | 1 | Program counter advance pulse |

## Verification
The assertions assume that `mem_rdata` and `rf_rdata` are combinational responses to the same cycle's `mem_addr` and `rf_raddr`. They also assume that requests which arrive while `req_ready` is low are simply held and not counted. The step-size properties apply only when no load rewrites the unit's own registers, so they cannot be spoiled by a load overwriting the register being tracked. The stimulus drives every request as a full handshake and answers both read ports from bench-owned models inside the same cycle. It sends the second half of a paired request only through the unit's own pending slot.

// File: rtl/agu_pkg.sv
package agu_pkg;
   localparam int RSEL_W = 5;

   typedef enum logic [1:0] {
      UPD_KEEP  = 2'd0,
      UPD_DEC   = 2'd1,
      UPD_INC   = 2'd2,
      UPD_ADDIX = 2'd3
   } upd_e;
endpackage

// File: rtl/agu_postmod.sv
module agu_postmod
   import agu_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic [DW-1:0] base,
   input  logic [DW-1:0] idx,
   input  upd_e          mode,
   output logic [DW-1:0] next
);
   localparam logic [DW-1:0] ONE = DW'(1);

   always_comb begin
      unique case (mode)
         UPD_KEEP:  next = base;
         UPD_DEC:   next = base - ONE;
         UPD_INC:   next = base + ONE;
         default:   next = base + idx;
      endcase
   end
endmodule

// File: rtl/agu_regbank.sv
module agu_regbank
   import agu_pkg::*;
#(
   parameter int DW  = 16,
   parameter int NAR = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              upd_en,
   input  logic [$clog2(NAR)-1:0] upd_sel,
   input  logic [DW-1:0]     upd_val,
   input  logic              ld_en,
   input  logic [RSEL_W-1:0] ld_sel,
   input  logic [DW-1:0]     ld_val,
   output logic [DW-1:0]     base,
   output logic [DW-1:0]     idx,
   input  logic [RSEL_W-1:0] rd_sel,
   output logic              rd_int,
   output logic [DW-1:0]     rd_val
);
   localparam int ARSEL_W = $clog2(NAR);

   logic [DW-1:0] ar_q [NAR];
   logic [DW-1:0] ix_q [NAR];

   for (genvar i = 0; i < NAR; i++) begin : g_pair
      always_ff @(posedge clk) begin
         if (rst) begin
            ar_q[i] <= '0;
         end else if (ld_en && ld_sel == RSEL_W'(i)) begin
            ar_q[i] <= ld_val;
         end else if (upd_en && upd_sel == ARSEL_W'(i)) begin
            ar_q[i] <= upd_val;
         end
      end

      always_ff @(posedge clk) begin
         if (rst) begin
            ix_q[i] <= '0;
         end else if (ld_en && ld_sel == RSEL_W'(NAR + i)) begin
            ix_q[i] <= ld_val;
         end
      end
   end

   assign base   = ar_q[upd_sel];
   assign idx    = ix_q[upd_sel];
   assign rd_int = rd_sel < RSEL_W'(2 * NAR);

   always_comb begin
      if (rd_sel[ARSEL_W]) rd_val = ix_q[rd_sel[ARSEL_W-1:0]];
      else                 rd_val = ar_q[rd_sel[ARSEL_W-1:0]];
   end
endmodule

// File: rtl/agu_slot_seq.sv
module agu_slot_seq
   import agu_pkg::*;
#(
   parameter int NAR         = 4,
   parameter int EXT_FW      = 2,
   parameter int EXT_LD_BASE = 24,
   parameter int EXT_ST_BASE = 28
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              main_en,
   input  logic              main_store,
   input  logic [1:0]        main_mode,
   input  logic [$clog2(NAR)-1:0] main_ar,
   input  logic [RSEL_W-1:0] main_rsel,
   input  logic              ext_en,
   input  logic              ext_store,
   input  logic              ext_addidx,
   input  logic [$clog2(NAR)-1:0] ext_ar,
   input  logic [EXT_FW-1:0] ext_field,
   output logic              op_valid,
   output logic              op_main,
   output logic              op_store,
   output upd_e              op_mode,
   output logic [$clog2(NAR)-1:0] op_ar,
   output logic [RSEL_W-1:0] op_rsel
);
   localparam int ARSEL_W = $clog2(NAR);
   localparam logic [RSEL_W-1:0] LD_B = RSEL_W'(EXT_LD_BASE);
   localparam logic [RSEL_W-1:0] ST_B = RSEL_W'(EXT_ST_BASE);

   logic               pend_q;
   logic               pend_store_q;
   upd_e               pend_mode_q;
   logic [ARSEL_W-1:0] pend_ar_q;
   logic [RSEL_W-1:0]  pend_rsel_q;

   logic              accept;
   upd_e              ext_mode;
   logic [RSEL_W-1:0] ext_rsel;

   assign req_ready = !pend_q;
   assign accept    = req_valid && !pend_q;
   assign ext_mode  = ext_addidx ? UPD_ADDIX : UPD_INC;
   assign ext_rsel  = (ext_store ? ST_B : LD_B) + RSEL_W'(ext_field);

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q       <= 1'b0;
         pend_store_q <= 1'b0;
         pend_mode_q  <= UPD_INC;
         pend_ar_q    <= '0;
         pend_rsel_q  <= '0;
      end else if (pend_q) begin
         pend_q <= 1'b0;
      end else if (accept && main_en && ext_en) begin
         pend_q       <= 1'b1;
         pend_store_q <= ext_store;
         pend_mode_q  <= ext_mode;
         pend_ar_q    <= ext_ar;
         pend_rsel_q  <= ext_rsel;
      end
   end

   always_comb begin
      op_valid = pend_q || (accept && (main_en || ext_en));
      op_main  = accept && main_en;
      if (pend_q) begin
         op_store = pend_store_q;
         op_mode  = pend_mode_q;
         op_ar    = pend_ar_q;
         op_rsel  = pend_rsel_q;
      end else if (main_en) begin
         op_store = main_store;
         op_mode  = upd_e'(main_mode);
         op_ar    = main_ar;
         op_rsel  = main_rsel;
      end else begin
         op_store = ext_store;
         op_mode  = ext_mode;
         op_ar    = ext_ar;
         op_rsel  = ext_rsel;
      end
   end
endmodule

// File: rtl/dsp_agu.sv
module dsp_agu
   import agu_pkg::*;
#(
   parameter int DW          = 16,
   parameter int NAR         = 4,
   parameter int EXT_FW      = 2,
   parameter int EXT_LD_BASE = 24,
   parameter int EXT_ST_BASE = 28
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              main_en,
   input  logic              main_store,
   input  logic [1:0]        main_mode,
   input  logic [$clog2(NAR)-1:0] main_ar,
   input  logic [RSEL_W-1:0] main_rsel,
   input  logic              ext_en,
   input  logic              ext_store,
   input  logic              ext_addidx,
   input  logic [$clog2(NAR)-1:0] ext_ar,
   input  logic [EXT_FW-1:0] ext_field,
   output logic              mem_en,
   output logic              mem_we,
   output logic [DW-1:0]     mem_addr,
   output logic [DW-1:0]     mem_wdata,
   input  logic [DW-1:0]     mem_rdata,
   output logic              rf_we,
   output logic [RSEL_W-1:0] rf_waddr,
   output logic [DW-1:0]     rf_wdata,
   output logic [RSEL_W-1:0] rf_raddr,
   input  logic [DW-1:0]     rf_rdata,
   output logic              pc_inc
);
   localparam int ARSEL_W = $clog2(NAR);
   localparam int NREG    = 2 * NAR;

   if (NAR < 2 || (1 << ARSEL_W) != NAR) begin : g_bad_nar
      $error("dsp_agu: NAR must be a power of two of at least 2");
   end
   if (NREG > EXT_LD_BASE || NREG > EXT_ST_BASE) begin : g_bad_base
      $error("dsp_agu: extension register bases overlap the local bank");
   end
   if (EXT_LD_BASE + (1 << EXT_FW) > (1 << RSEL_W) ||
       EXT_ST_BASE + (1 << EXT_FW) > (1 << RSEL_W)) begin : g_bad_fw
      $error("dsp_agu: extension register range exceeds register numbering");
   end

   logic               op_valid;
   logic               op_main;
   logic               op_store;
   upd_e               op_mode;
   logic [ARSEL_W-1:0] op_ar;
   logic [RSEL_W-1:0]  op_rsel;
   logic [DW-1:0]      base, idx, next, rd_val;
   logic               rd_int;

   agu_slot_seq #(
      .NAR(NAR), .EXT_FW(EXT_FW),
      .EXT_LD_BASE(EXT_LD_BASE), .EXT_ST_BASE(EXT_ST_BASE)
   ) u_seq (
      .clk(clk), .rst(rst),
      .req_valid(req_valid), .req_ready(req_ready),
      .main_en(main_en), .main_store(main_store), .main_mode(main_mode),
      .main_ar(main_ar), .main_rsel(main_rsel),
      .ext_en(ext_en), .ext_store(ext_store), .ext_addidx(ext_addidx),
      .ext_ar(ext_ar), .ext_field(ext_field),
      .op_valid(op_valid), .op_main(op_main), .op_store(op_store),
      .op_mode(op_mode), .op_ar(op_ar), .op_rsel(op_rsel)
   );

   agu_regbank #(.DW(DW), .NAR(NAR)) u_bank (
      .clk(clk), .rst(rst),
      .upd_en(op_valid), .upd_sel(op_ar), .upd_val(next),
      .ld_en(op_valid && !op_store && rd_int), .ld_sel(op_rsel), .ld_val(mem_rdata),
      .base(base), .idx(idx),
      .rd_sel(op_rsel), .rd_int(rd_int), .rd_val(rd_val)
   );

   agu_postmod #(.DW(DW)) u_pm (
      .base(base), .idx(idx), .mode(op_mode), .next(next)
   );

   assign mem_en    = op_valid;
   assign mem_we    = op_valid && op_store;
   assign mem_addr  = base;
   assign mem_wdata = rd_int ? rd_val : rf_rdata;
   assign rf_raddr  = op_rsel;
   assign rf_we     = op_valid && !op_store;
   assign rf_waddr  = op_rsel;
   assign rf_wdata  = mem_rdata;
   assign pc_inc    = op_main;
endmodule

// File: rtl/agu_chk.sv
module agu_chk #(
   parameter int DW   = 16,
   parameter int ASW  = 2,
   parameter int RSW  = 5,
   parameter int NREG = 8
) (
   input logic           clk,
   input logic           rst,
   input logic           req_valid,
   input logic           req_ready,
   input logic           main_en,
   input logic           ext_en,
   input logic           mem_en,
   input logic           mem_we,
   input logic [DW-1:0]  mem_addr,
   input logic [DW-1:0]  mem_rdata,
   input logic           rf_we,
   input logic           pc_inc,
   input logic [1:0]     op_mode,
   input logic [ASW-1:0] op_ar,
   input logic [RSW-1:0] op_rsel
);
   logic own_load;
   assign own_load = rf_we && (op_rsel < RSW'(NREG));

   AST_PEND_ONE: assert property (@(posedge clk) disable iff (rst)
      !req_ready |=> req_ready);  // R8
   AST_EXT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready && main_en && ext_en) |=> (mem_en && !req_ready));  // R8
   AST_INC_STEP: assert property (@(posedge clk) disable iff (rst)
      (mem_en && op_mode == 2'd2 && !own_load) |=>
      (!mem_en || op_ar != $past(op_ar) || mem_addr == $past(mem_addr) + DW'(1)));  // R3
   AST_DEC_STEP: assert property (@(posedge clk) disable iff (rst)
      (mem_en && op_mode == 2'd1 && !own_load) |=>
      (!mem_en || op_ar != $past(op_ar) || mem_addr == $past(mem_addr) - DW'(1)));  // R3
   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
      (mem_en && !mem_we && op_rsel == RSW'(op_ar)) |=>
      (!mem_en || op_ar != $past(op_ar) || mem_addr == $past(mem_rdata)));  // R9
   AST_LOAD_PORT: assert property (@(posedge clk) disable iff (rst)
      rf_we |-> (mem_en && !mem_we));  // R10
   AST_STORE_NO_WR: assert property (@(posedge clk) disable iff (rst)
      mem_we |-> !rf_we);  // R10
   AST_PC_MAIN: assert property (@(posedge clk) disable iff (rst)
      pc_inc |-> (mem_en && req_ready && main_en));  // R12
endmodule

bind dsp_agu agu_chk #(.DW(DW), .ASW(ARSEL_W), .RSW(agu_pkg::RSEL_W), .NREG(NREG)) u_chk (
   .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
   .main_en(main_en), .ext_en(ext_en),
   .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
   .rf_we(rf_we), .pc_inc(pc_inc),
   .op_mode(op_mode), .op_ar(op_ar), .op_rsel(op_rsel)
);

// File: tb/dsp_agu_bench.sv
module dsp_agu_bench;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        main_en = 1'b0, main_store = 1'b0;
   logic [1:0]  main_mode = '0, main_ar = '0;
   logic [4:0]  main_rsel = '0;
   logic        ext_en = 1'b0, ext_store = 1'b0, ext_addidx = 1'b0;
   logic [1:0]  ext_ar = '0, ext_field = '0;
   logic        mem_en, mem_we, rf_we, pc_inc;
   logic [15:0] mem_addr, mem_wdata, mem_rdata, rf_wdata, rf_rdata;
   logic [4:0]  rf_waddr, rf_raddr;

   logic [15:0] mem [256];
   logic [15:0] m_ar [4];
   logic [15:0] m_ix [4];
   int total = 0;
   int bad = 0;
   bit done = 0;

   always #(CLK_P/2) clk = ~clk;

   function automatic logic [15:0] ext_val(input logic [4:0] r);
      return {r, 11'h2B5};
   endfunction

   assign mem_rdata = mem[mem_addr[7:0]];
   assign rf_rdata  = ext_val(rf_raddr);

   always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

   dsp_agu u_dsp_agu (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .main_en(main_en), .main_store(main_store), .main_mode(main_mode),
      .main_ar(main_ar), .main_rsel(main_rsel),
      .ext_en(ext_en), .ext_store(ext_store), .ext_addidx(ext_addidx),
      .ext_ar(ext_ar), .ext_field(ext_field),
      .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
      .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .pc_inc(pc_inc)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] model_reg(input logic [4:0] r);
      if (r < 5'd4) return m_ar[r[1:0]];
      if (r < 5'd8) return m_ix[r[1:0]];
      return ext_val(r);
   endfunction

   // one access cycle: sample before the edge, then fold the expected update into the model
   task automatic do_acc(input bit is_main, input bit st, input logic [1:0] mode,
                         input logic [1:0] a, input logic [4:0] r, input string tag);
      logic [15:0] old_a, na, rd;
      old_a = m_ar[a];
      rd    = mem[old_a[7:0]];
      check(mem_en == 1'b1, "R2", "mem_en", 16'(mem_en), 16'd1);
      check(mem_addr == old_a, tag, "mem_addr", mem_addr, old_a);
      check(mem_we == st, "R10", "mem_we", 16'(mem_we), 16'(st));
      check(pc_inc == is_main, "R12", "pc_inc", 16'(pc_inc), 16'(is_main));
      if (st) begin
         check(rf_we == 1'b0, "R10", "rf_we on store", 16'(rf_we), 16'd0);
         check(mem_wdata == model_reg(r), is_main ? "R11" : "R7", "mem_wdata",
               mem_wdata, model_reg(r));
      end else begin
         check(rf_we == 1'b1 && rf_waddr == r, is_main ? "R10" : "R6", "rf_waddr",
               16'(rf_waddr), 16'(r));
         check(rf_wdata == rd, "R10", "rf_wdata", rf_wdata, rd);
      end
      case (mode)
         2'd0: na = old_a;
         2'd1: na = old_a - 16'd1;
         2'd2: na = old_a + 16'd1;
         default: na = old_a + m_ix[a];
      endcase
      @(posedge clk);
      m_ar[a] = na;
      if (!st && r < 5'd4) m_ar[r[1:0]] = rd;
      else if (!st && r < 5'd8) m_ix[r[1:0]] = rd;
   endtask

   task automatic req(input bit me, input bit ms, input logic [1:0] mm, input logic [1:0] ma,
                      input logic [4:0] mr, input bit ee, input bit es, input bit ea,
                      input logic [1:0] ear, input logic [1:0] ef, input string tag);
      logic [4:0] er;
      er = es ? 5'd28 + 5'(ef) : 5'd24 + 5'(ef);
      @(negedge clk);
      req_valid = 1'b1; main_en = me; main_store = ms; main_mode = mm; main_ar = ma;
      main_rsel = mr; ext_en = ee; ext_store = es; ext_addidx = ea; ext_ar = ear;
      ext_field = ef;
      #1;
      check(req_ready == 1'b1, "R8", "req_ready idle", 16'(req_ready), 16'd1);
      if (me) do_acc(1'b1, ms, mm, ma, mr, tag);
      else    do_acc(1'b0, es, ea ? 2'd3 : 2'd2, ear, er, tag);
      @(negedge clk);
      req_valid = 1'b0; main_en = 1'b0; ext_en = 1'b0;
      #1;
      if (me && ee) begin
         check(req_ready == 1'b0, "R8", "req_ready during extension", 16'(req_ready), 16'd0);
         do_acc(1'b0, es, ea ? 2'd3 : 2'd2, ear, er, "R8");
      end else begin
         check(mem_en == 1'b0, "R8", "no second access", 16'(mem_en), 16'd0);
      end
   endtask

   initial begin
      #(CLK_P * 20000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog act=%h exp=%h", 16'd0, 16'd1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 16'(i * 257 + 3);
      for (int i = 0; i < 4; i++) begin m_ar[i] = '0; m_ix[i] = '0; end
      mem[0] = 16'h0003; mem[1] = 16'hFFFE; mem[2] = 16'h0005; mem[3] = 16'h8001;
      mem[4] = 16'h0010; mem[5] = 16'h0020; mem[6] = 16'hFFFF; mem[7] = 16'h0040;
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 1'b0; #1;
      check(mem_en == 1'b0 && rf_we == 1'b0 && pc_inc == 1'b0, "R1", "idle outputs",
            {13'd0, mem_en, rf_we, pc_inc}, 16'd0);
      // R1: every register reads back zero after reset
      for (int k = 0; k < 4; k++) req(1, 0, 2'd0, 2'(k), 5'd9, 0, 0, 0, 2'd0, 2'd0, "R1");
      for (int k = 4; k < 8; k++) req(1, 1, 2'd0, 2'd0, 5'(k), 0, 0, 0, 2'd0, 2'd0, "R1");
      // R5: decrement from zero wraps
      req(1, 0, 2'd1, 2'd1, 5'd10, 0, 0, 0, 2'd0, 2'd0, "R2");
      req(1, 0, 2'd0, 2'd1, 5'd10, 0, 0, 0, 2'd0, 2'd0, "R5");
      // seed index and address registers through loads, R4 numbering
      for (int k = 4; k < 8; k++) req(1, 0, 2'd2, 2'd0, 5'(k), 0, 0, 0, 2'd0, 2'd0, "R4");
      for (int k = 1; k < 4; k++) req(1, 0, 2'd2, 2'd0, 5'(k), 0, 0, 0, 2'd0, 2'd0, "R4");
      // R9: load into the register being post-incremented
      req(1, 0, 2'd2, 2'd0, 5'd0, 0, 0, 0, 2'd0, 2'd0, "R2");
      req(1, 0, 2'd0, 2'd0, 5'd12, 0, 0, 0, 2'd0, 2'd0, "R9");
      // R5: increment from FFFF wraps, then add negative index
      req(1, 0, 2'd2, 2'd3, 5'd12, 0, 0, 0, 2'd0, 2'd0, "R2");
      req(1, 0, 2'd3, 2'd3, 5'd12, 0, 0, 0, 2'd0, 2'd0, "R5");
      req(1, 0, 2'd3, 2'd1, 5'd12, 0, 0, 0, 2'd0, 2'd0, "R5");
      // main sweep: every register, every mode, load and store, R3 R4 R11
      for (int pass = 0; pass < 2; pass++)
         for (int k = 0; k < 4; k++)
            for (int m = 0; m < 4; m++)
               for (int st = 0; st < 2; st++)
                  req(1, 1'(st), 2'(m), 2'(k),
                      st != 0 ? (((k + m + pass) % 2) != 0 ? 5'((k * 2 + m) % 8) : 5'(9 + m))
                              : 5'(8 + k * 4 + m),
                      0, 0, 0, 2'd0, 2'd0, m == 3 ? "R4" : "R3");
      // extension-only sweep, R6 R7
      for (int k = 0; k < 4; k++)
         for (int st = 0; st < 2; st++)
            for (int ad = 0; ad < 2; ad++)
               for (int f = 0; f < 4; f++)
                  req(0, 0, 2'd0, 2'd0, 5'd0, 1, 1'(st), 1'(ad), 2'(k), 2'(f),
                      st != 0 ? "R7" : "R6");
      // paired requests, R8: same and different address registers
      for (int k = 0; k < 4; k++)
         for (int m = 0; m < 4; m++)
            req(1, 1'(m % 2), 2'(m), 2'(k), m % 2 != 0 ? 5'(4 + k) : 5'(16 + m),
                1, 1'(k % 2), 1'(m / 2), 2'((k + m / 2) % 4), 2'(m), "R8");
      // R9 with decrement into an index-paired address register
      req(1, 0, 2'd1, 2'd2, 5'd2, 0, 0, 0, 2'd0, 2'd0, "R2");
      req(1, 0, 2'd0, 2'd2, 5'd8, 0, 0, 0, 2'd0, 2'd0, "R9");
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule